// File: doc/BRIEF.md
# Concurrent-Write Conflict Resolver

This block fronts a small single-cycle word memory shared by several processor ports. In every clock cycle each port may present a write (enable, word address, data word) and a read (enable, word address). Writes that land on different addresses all take effect at the next clock edge. When two or more ports write one address in the same cycle, a run-time policy input decides the result. The policies are: all values must agree, one rotating winner, fixed ranking by port index, or the stored word is the sum of the values.

Two checking switches sit above the policies. With the exclusive-write switch set, any shared write address is treated as illegal: those writes are dropped and an error pulse is raised. With the exclusive-read switch set, two ports reading one address raise the same pulse. Each port gets a registered success bit and a registered overflow bit one cycle after its request. Read data is combinational by default, and a parameter selects a registered read path instead. The block has no multi-state controller. Its only sequential state is the storage array, the rotating winner pointer and the status registers.

Top module: `cwrite_resolver`

## Requirements
- R1: Writes from any set of ports to pairwise different addresses are all stored at the next clock edge, and each requesting port sees wr_ok high in the cycle after its request.
- R2: Any number of ports may read one address in the same cycle. Each rd_data lane shows the word stored at its rd_addr (combinational read, default), and with the exclusive-read switch off this never raises conflict_err.
- R3: Policy code 0 (common): when the writers of one address all present the same value, that value is stored and all of them succeed. Otherwise nothing is stored at that address and all of them fail.
- R4: Policy code 1 (arbitrary): of the writers sharing an address, the one that is first in cyclic port order starting at the rotating pointer stores its value and succeeds, and the others fail. The pointer is 0 after reset. It advances by one, modulo the port count, after every cycle in this policy (exclusive-write off) that has at least one shared write address.
- R5: Policy code 2 (priority): of the writers sharing an address, the lowest port index stores its value and succeeds, and the others fail.
- R6: Policy code 3 (sum): the sum of all values written to an address, taken modulo 2^DW, is stored, and every writer succeeds. When the full sum is 2^DW or more, wr_ovf is high for every writer of that address in the cycle after the request. Otherwise wr_ovf is low.
- R7: With excl_wr high, every write to an address written by two or more ports is dropped and fails, whatever the policy. Writes to unshared addresses still complete. conflict_err is high in the cycle after such a request and low after a cycle without a violation.
- R8: With excl_rd high, two or more ports with rd_en high on one rd_addr set conflict_err in the following cycle. Read data is still returned.
- R9: After reset every word reads 0, and wr_ok, wr_ovf and conflict_err are 0.
- R10: wr_ok and wr_ovf of a port with wr_en low are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy | input | 2 | Conflict policy: 0 common, 1 arbitrary, 2 priority, 3 sum |
| excl_wr | input | 1 | Treat shared write addresses as illegal |
| excl_rd | input | 1 | Treat shared read addresses as illegal |
| wr_en | input | NPORT | Write request per port |
| wr_addr | input | NPORT x AW | Write word address per port |
| wr_data | input | NPORT x DW | Write data per port |
| rd_en | input | NPORT | Read request per port |
| rd_addr | input | NPORT x AW | Read word address per port |
| rd_data | output | NPORT x DW | Read data per port |
| wr_ok | output | NPORT | Registered write success per port |
| wr_ovf | output | NPORT | Registered sum-overflow per port |
| conflict_err | output | 1 | One-cycle pulse on an exclusive-access violation |

## Verification
Directed cases separate the policies on the same address clash. Equal and unequal values tell common mode apart from the others. A clash with a high-index writer alongside a low-index one separates priority from arbitrary. A sequence of clashes with different member sets walks the rotating pointer through every position, and single-writer cycles in between show that the pointer stays put without a clash. Sums above and below the word range tell the wrap and overflow flag apart. Exclusive-write cycles mix clashing and clean writes to show that only the clashing ones are dropped. A long run of random traffic on few addresses is compared every clock against a per-address behavioural model.

// File: rtl/cwr_pkg.sv
package cwr_pkg;
    typedef enum logic [1:0] {
        POL_COMMON = 2'd0,
        POL_ARBIT  = 2'd1,
        POL_PRIO   = 2'd2,
        POL_SUM    = 2'd3
    } policy_e;
endpackage

// File: rtl/cwr_match.sv
// Address-match matrix and per-group facts seen from each port.
module cwr_match #(
    parameter int NPORT = 4,
    parameter int AW    = 3,
    parameter int DW    = 8,
    localparam int SW   = DW + $clog2(NPORT) + 1
) (
    input  logic [NPORT-1:0]          wr_en,
    input  logic [NPORT-1:0][AW-1:0]  wr_addr,
    input  logic [NPORT-1:0][DW-1:0]  wr_data,
    output logic [NPORT-1:0][NPORT-1:0] same,
    output logic [NPORT-1:0]          leader,
    output logic [NPORT-1:0]          clash,
    output logic [NPORT-1:0]          all_eq,
    output logic [NPORT-1:0][SW-1:0]  grp_sum
);
    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            for (int j = 0; j < NPORT; j++) begin
                same[i][j] = wr_en[i] & wr_en[j] & (wr_addr[i] == wr_addr[j]);
            end
        end
    end

    generate
        for (genvar gi = 0; gi < NPORT; gi++) begin : g_port
            always_comb begin
                int cnt;
                cnt = 0;
                leader[gi]  = wr_en[gi];
                all_eq[gi]  = 1'b1;
                grp_sum[gi] = '0;
                for (int j = 0; j < NPORT; j++) begin
                    if (same[gi][j]) begin
                        cnt = cnt + 1;
                        grp_sum[gi] = grp_sum[gi] + SW'(wr_data[j]);
                        if (wr_data[j] != wr_data[gi]) all_eq[gi] = 1'b0;
                        if (j < gi) leader[gi] = 1'b0;
                    end
                end
                clash[gi] = (cnt > 1);
            end
        end
    endgenerate
endmodule

// File: rtl/cwr_rr_ptr.sv
// Rotating start pointer for the arbitrary policy.
module cwr_rr_ptr #(
    parameter int NPORT = 4,
    localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    output logic [PW-1:0] ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (advance) begin
            if (ptr == PW'(NPORT - 1)) ptr <= '0;
            else                       ptr <= ptr + 1'b1;
        end
    end

    p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != $past(ptr)) |->
        (ptr == (($past(ptr) == PW'(NPORT - 1)) ? PW'(0) : PW'($past(ptr) + 1'b1))))
        else $error("pointer moved by other than one step");
endmodule

// File: rtl/cwr_resolve.sv
// Applies the selected policy to each address group.
module cwr_resolve
    import cwr_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int DW    = 8,
    localparam int SW   = DW + $clog2(NPORT) + 1,
    localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  policy_e                   pol,
    input  logic                      excl_wr,
    input  logic [PW-1:0]             ptr,
    input  logic [NPORT-1:0]          wr_en,
    input  logic [NPORT-1:0][DW-1:0]  wr_data,
    input  logic [NPORT-1:0][NPORT-1:0] same,
    input  logic [NPORT-1:0]          leader,
    input  logic [NPORT-1:0]          clash,
    input  logic [NPORT-1:0]          all_eq,
    input  logic [NPORT-1:0][SW-1:0]  grp_sum,
    output logic [NPORT-1:0]          we,
    output logic [NPORT-1:0][DW-1:0]  wval,
    output logic [NPORT-1:0]          ok_nx,
    output logic [NPORT-1:0]          ovf_nx,
    output logic                      advance,
    output logic                      wr_violation
);
    logic [NPORT-1:0] arb_win;
    logic             any_clash;

    // distance from the pointer in cyclic port order
    function automatic int dist_of(int idx, logic [PW-1:0] p);
        int d;
        d = idx + NPORT - int'(p);
        if (d >= NPORT) d = d - NPORT;
        return d;
    endfunction

    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            arb_win[i] = wr_en[i];
            for (int j = 0; j < NPORT; j++) begin
                if (same[i][j] && (j != i) && (dist_of(j, ptr) < dist_of(i, ptr)))
                    arb_win[i] = 1'b0;
            end
        end
    end

    assign any_clash    = |clash;
    assign advance      = (pol == POL_ARBIT) & ~excl_wr & any_clash;
    assign wr_violation = excl_wr & any_clash;

    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            we[i]     = 1'b0;
            wval[i]   = wr_data[i];
            ok_nx[i]  = 1'b0;
            ovf_nx[i] = 1'b0;
            if (excl_wr) begin
                ok_nx[i] = wr_en[i] & ~clash[i];
                we[i]    = ok_nx[i];
            end else begin
                unique case (pol)
                    POL_COMMON: begin
                        ok_nx[i] = wr_en[i] & (~clash[i] | all_eq[i]);
                        we[i]    = ok_nx[i] & leader[i];
                    end
                    POL_ARBIT: begin
                        ok_nx[i] = arb_win[i];
                        we[i]    = arb_win[i];
                    end
                    POL_PRIO: begin
                        ok_nx[i] = leader[i];
                        we[i]    = leader[i];
                    end
                    POL_SUM: begin
                        ok_nx[i]  = wr_en[i];
                        we[i]     = leader[i];
                        wval[i]   = grp_sum[i][DW-1:0];
                        ovf_nx[i] = wr_en[i] & (grp_sum[i][SW-1:DW] != '0);
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/cwr_store.sv
// Word storage with one write lane and one read lane per port.
module cwr_store #(
    parameter int NPORT  = 4,
    parameter int AW     = 3,
    parameter int DW     = 8,
    parameter bit REG_RD = 1'b0,
    localparam int DEPTH = 1 << AW
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NPORT-1:0]          we,
    input  logic [NPORT-1:0][AW-1:0]  waddr,
    input  logic [NPORT-1:0][DW-1:0]  wval,
    input  logic [NPORT-1:0]          rd_en,
    input  logic [NPORT-1:0][AW-1:0]  rd_addr,
    output logic [NPORT-1:0][DW-1:0]  rd_data
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
        end else begin
            for (int i = 0; i < NPORT; i++) begin
                if (we[i]) mem[waddr[i]] <= wval[i];
            end
        end
    end

    generate
        if (REG_RD) begin : g_rd_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    rd_data <= '0;
                end else begin
                    for (int i = 0; i < NPORT; i++) begin
                        if (rd_en[i]) rd_data[i] <= mem[rd_addr[i]];
                    end
                end
            end
        end else begin : g_rd_comb
            always_comb begin
                for (int i = 0; i < NPORT; i++) rd_data[i] = mem[rd_addr[i]];
            end
        end
    endgenerate

    // the resolver must hand at most one writer to each address (R1)
    generate
        for (genvar gi = 0; gi < NPORT; gi++) begin : g_chk_i
            for (genvar gj = gi + 1; gj < NPORT; gj++) begin : g_chk_j
                p_one_writer_r1: assert property (@(posedge clk) disable iff (!rst_n)
                    (we[gi] && we[gj]) |-> (waddr[gi] != waddr[gj]))
                    else $error("two writers on one address");
            end
        end
    endgenerate
endmodule

// File: rtl/cwrite_resolver.sv
module cwrite_resolver
    import cwr_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int AW     = 3,
    parameter int DW     = 8,
    parameter bit REG_RD = 1'b0,
    localparam int SW    = DW + $clog2(NPORT) + 1,
    localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                policy,
    input  logic                      excl_wr,
    input  logic                      excl_rd,
    input  logic [NPORT-1:0]          wr_en,
    input  logic [NPORT-1:0][AW-1:0]  wr_addr,
    input  logic [NPORT-1:0][DW-1:0]  wr_data,
    input  logic [NPORT-1:0]          rd_en,
    input  logic [NPORT-1:0][AW-1:0]  rd_addr,
    output logic [NPORT-1:0][DW-1:0]  rd_data,
    output logic [NPORT-1:0]          wr_ok,
    output logic [NPORT-1:0]          wr_ovf,
    output logic                      conflict_err
);
    policy_e                    pol;
    logic [NPORT-1:0][NPORT-1:0] same;
    logic [NPORT-1:0]           leader, clash, all_eq;
    logic [NPORT-1:0][SW-1:0]   grp_sum;
    logic [NPORT-1:0]           we, ok_nx, ovf_nx;
    logic [NPORT-1:0][DW-1:0]   wval;
    logic                       advance, wr_violation, rd_violation;
    logic [PW-1:0]              ptr;

    assign pol = policy_e'(policy);

    cwr_match #(.NPORT(NPORT), .AW(AW), .DW(DW)) i_match (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .same(same), .leader(leader), .clash(clash),
        .all_eq(all_eq), .grp_sum(grp_sum)
    );

    cwr_rr_ptr #(.NPORT(NPORT)) i_ptr (
        .clk(clk), .rst_n(rst_n), .advance(advance), .ptr(ptr)
    );

    cwr_resolve #(.NPORT(NPORT), .DW(DW)) i_resolve (
        .pol(pol), .excl_wr(excl_wr), .ptr(ptr),
        .wr_en(wr_en), .wr_data(wr_data),
        .same(same), .leader(leader), .clash(clash),
        .all_eq(all_eq), .grp_sum(grp_sum),
        .we(we), .wval(wval), .ok_nx(ok_nx), .ovf_nx(ovf_nx),
        .advance(advance), .wr_violation(wr_violation)
    );

    cwr_store #(.NPORT(NPORT), .AW(AW), .DW(DW), .REG_RD(REG_RD)) i_store (
        .clk(clk), .rst_n(rst_n),
        .we(we), .waddr(wr_addr), .wval(wval),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // shared read address check
    always_comb begin
        rd_violation = 1'b0;
        for (int i = 0; i < NPORT; i++) begin
            for (int j = i + 1; j < NPORT; j++) begin
                if (rd_en[i] && rd_en[j] && (rd_addr[i] == rd_addr[j]))
                    rd_violation = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ok        <= '0;
            wr_ovf       <= '0;
            conflict_err <= 1'b0;
        end else begin
            wr_ok        <= ok_nx;
            wr_ovf       <= ovf_nx;
            conflict_err <= wr_violation | (excl_rd & rd_violation);
        end
    end

    generate
        for (genvar gi = 0; gi < NPORT; gi++) begin : g_chk
            p_ok_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
                wr_ok[gi] |-> $past(wr_en[gi]))
                else $error("success without request");
            p_ovf_needs_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
                wr_ovf[gi] |-> ($past(policy) == 2'd3 && !$past(excl_wr) && wr_ok[gi]))
                else $error("overflow outside sum policy");
        end
    endgenerate

    p_err_needs_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_err |-> ($past(excl_wr) || $past(excl_rd)))
        else $error("error pulse with checks off");
endmodule

// File: tb/test_cwrite_resolver.sv
`timescale 1ns/1ps
module test_cwrite_resolver;
    localparam int N  = 4;
    localparam int AW = 3;
    localparam int DW = 8;
    localparam int D  = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] policy = 2'd0;
    logic excl_wr = 1'b0, excl_rd = 1'b0;
    logic [N-1:0] wr_en = '0, rd_en = '0;
    logic [N-1:0][AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [N-1:0][DW-1:0] wr_data = '0;
    logic [N-1:0][DW-1:0] rd_data;
    logic [N-1:0] wr_ok, wr_ovf;
    logic conflict_err;

    always #5 clk = ~clk;

    cwrite_resolver #(.NPORT(N), .AW(AW), .DW(DW)) i_cwrite_resolver (
        .clk(clk), .rst_n(rst_n), .policy(policy), .excl_wr(excl_wr), .excl_rd(excl_rd),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_ok(wr_ok), .wr_ovf(wr_ovf), .conflict_err(conflict_err)
    );

    int errors = 0;
    int checks = 0;
    int mmem [D];
    int mptr = 0;
    logic [N-1:0] e_ok, e_ovf;
    logic e_err;

    task automatic check(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // behavioural model: walk addresses, collect their writers
    task automatic model_cycle();
        bit any_clash = 0;
        e_ok = '0; e_ovf = '0; e_err = 0;
        for (int a = 0; a < D; a++) begin
            int q[$];
            q = {};
            for (int p = 0; p < N; p++)
                if (wr_en[p] && int'(wr_addr[p]) == a) q.push_back(p);
            if (q.size() == 1) begin
                mmem[a] = int'(wr_data[q[0]]);
                e_ok[q[0]] = 1;
            end else if (q.size() > 1) begin
                any_clash = 1;
                if (excl_wr) begin
                    e_err = 1;
                end else if (policy == 2'd0) begin
                    bit eq = 1;
                    foreach (q[k]) if (wr_data[q[k]] != wr_data[q[0]]) eq = 0;
                    if (eq) begin
                        mmem[a] = int'(wr_data[q[0]]);
                        foreach (q[k]) e_ok[q[k]] = 1;
                    end
                end else if (policy == 2'd1) begin
                    int best = -1, bd = N;
                    foreach (q[k]) begin
                        int d = (q[k] - mptr + N) % N;
                        if (d < bd) begin bd = d; best = q[k]; end
                    end
                    mmem[a] = int'(wr_data[best]);
                    e_ok[best] = 1;
                end else if (policy == 2'd2) begin
                    mmem[a] = int'(wr_data[q[0]]);
                    e_ok[q[0]] = 1;
                end else begin
                    int s = 0;
                    foreach (q[k]) s += int'(wr_data[q[k]]);
                    mmem[a] = s % (1 << DW);
                    foreach (q[k]) begin
                        e_ok[q[k]] = 1;
                        e_ovf[q[k]] = (s >= (1 << DW));
                    end
                end
            end
        end
        if (any_clash && policy == 2'd1 && !excl_wr) mptr = (mptr + 1) % N;
        if (excl_rd)
            for (int i = 0; i < N; i++)
                for (int j = i + 1; j < N; j++)
                    if (rd_en[i] && rd_en[j] && rd_addr[i] == rd_addr[j]) e_err = 1;
    endtask

    // inputs already set after a negedge; check reads, clock, check status
    task automatic step(string tag);
        #1;
        for (int p = 0; p < N; p++)
            check(tag, $sformatf("rd_data[%0d]", p), rd_data[p], mmem[rd_addr[p]]);
        model_cycle();
        @(posedge clk);
        @(negedge clk);
        check(tag, "wr_ok", wr_ok, e_ok);
        check(tag, "wr_ovf", wr_ovf, e_ovf);
        check(tag, "conflict_err", conflict_err, e_err);
    endtask

    task automatic set_wr(int p, int a, int d);
        wr_en[p] = 1; wr_addr[p] = AW'(a); wr_data[p] = DW'(d);
    endtask

    task automatic idle();
        wr_en = '0; rd_en = '0; excl_wr = 0; excl_rd = 0;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int a = 0; a < D; a++) mmem[a] = 0;
        repeat (3) @(negedge clk);
        // R9 reset state
        for (int a = 0; a < D; a++) begin
            rd_addr[0] = AW'(a); #1;
            check("R9", "reset word", rd_data[0], 0);
        end
        check("R9", "reset ok", wr_ok, 0);
        check("R9", "reset err", conflict_err, 0);
        rst_n = 1;
        @(negedge clk);

        // R1 distinct addresses, R10 idle ports
        idle(); policy = 2'd0;
        set_wr(0, 0, 8'h11); set_wr(1, 1, 8'h22); set_wr(2, 2, 8'h33); set_wr(3, 3, 8'h44);
        step("R1");
        idle(); set_wr(2, 7, 8'h5a);
        step("R10");
        // R2 shared read, no error with checks off
        idle(); rd_en = '1; rd_addr = {AW'(2), AW'(2), AW'(2), AW'(2)};
        step("R2");
        // R3 common, equal values
        idle(); set_wr(0, 5, 8'h33); set_wr(1, 5, 8'h33); set_wr(2, 5, 8'h33); set_wr(3, 6, 8'h66);
        rd_addr = {AW'(5), AW'(6), AW'(5), AW'(6)};
        step("R3");
        // R3 common, unequal values
        idle(); set_wr(1, 5, 8'h01); set_wr(3, 5, 8'h02);
        step("R3");
        step("R3");
        // R5 priority
        idle(); policy = 2'd2;
        set_wr(1, 4, 8'ha1); set_wr(2, 4, 8'ha2); set_wr(3, 4, 8'ha3);
        rd_addr = {AW'(4), AW'(4), AW'(4), AW'(4)};
        step("R5");
        step("R5");
        // R4 arbitrary, walk the pointer
        policy = 2'd1; rd_addr = {AW'(7), AW'(7), AW'(7), AW'(7)};
        idle(); set_wr(1, 7, 8'hb1); set_wr(3, 7, 8'hb3); step("R4");
        idle(); set_wr(0, 7, 8'hc0); set_wr(2, 7, 8'hc2); step("R4");
        idle(); set_wr(0, 7, 8'hd0); set_wr(1, 7, 8'hd1); step("R4");
        idle(); set_wr(2, 6, 8'he2); step("R4");
        idle(); set_wr(0, 7, 8'hf0); set_wr(3, 7, 8'hf3); step("R4");
        idle(); set_wr(0, 7, 8'h10); set_wr(1, 7, 8'h11); set_wr(2, 7, 8'h12); set_wr(3, 7, 8'h13);
        step("R4");
        idle(); step("R4");
        // R6 sum with and without overflow
        policy = 2'd3; rd_addr = {AW'(3), AW'(3), AW'(2), AW'(3)};
        idle(); set_wr(0, 3, 8'h80); set_wr(1, 3, 8'h90); set_wr(2, 3, 8'h10); step("R6");
        idle(); set_wr(1, 3, 8'h05); set_wr(3, 3, 8'h07); set_wr(2, 2, 8'hff); step("R6");
        idle(); step("R6");
        // R7 exclusive write
        policy = 2'd2; rd_addr = {AW'(6), AW'(2), AW'(2), AW'(2)};
        idle(); excl_wr = 1; set_wr(0, 2, 8'h77); set_wr(1, 2, 8'h78); set_wr(2, 6, 8'h79);
        step("R7");
        idle(); excl_wr = 1; set_wr(3, 2, 8'h7a); step("R7");
        idle(); step("R7");
        // R8 exclusive read
        idle(); excl_rd = 1; rd_en = 4'b0011; rd_addr = {AW'(1), AW'(0), AW'(2), AW'(2)};
        step("R8");
        idle(); excl_rd = 1; rd_en = 4'b1111; rd_addr = {AW'(3), AW'(2), AW'(1), AW'(0)};
        step("R8");

        // random traffic across all policies and switches (R1 to R8)
        for (int c = 0; c < 400; c++) begin
            policy  = 2'($urandom_range(0, 3));
            excl_wr = ($urandom_range(0, 5) == 0);
            excl_rd = ($urandom_range(0, 5) == 0);
            for (int p = 0; p < N; p++) begin
                wr_en[p]   = ($urandom_range(0, 3) != 0);
                wr_addr[p] = AW'($urandom_range(0, 3));
                wr_data[p] = ($urandom_range(0, 2) == 0) ? DW'(8'h42) : DW'($urandom_range(0, 255));
                rd_en[p]   = $urandom_range(0, 1) == 1;
                rd_addr[p] = AW'($urandom_range(0, D - 1));
            end
            step("R3_R4_R5_R6");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule